// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host a byte-wide window onto the configuration bytes of a disk-channel controller. It uses only two I/O addresses. The host first writes a register index to the index port. It then reads or writes the selected byte through the data port, which sits four addresses above the index port.

A strap input places the index port at one of two base addresses, and software can read the strap back.

Behind the window sit ten configuration bytes at indices 0x50 to 0x59 and a scratch byte at 0x5B. Among other fields, these bytes hold:

- a fixed silicon revision;
- the live interrupt status of both channels;
- one prefetch-disable bit per drive;
- the secondary-channel enable;
- the prefetch burst setting;
- six timing bytes, which are brought out for the channel timing logic.

Top module: `cfgwin_port`

## Requirements
- R1: With `alt_sel`=0 the index port is at address 0x178 and the data port at 0x17C. With `alt_sel`=1 they are at 0x078 and 0x07C. An access at any other address is not claimed: `rd_ack` stays low and no state changes.
- R2: A write to the index port loads the 8-bit index register, which resets to 0x00. The index holds its value until it is rewritten, so any number of data-port accesses may follow one index write. A read of the index port returns the current index.
- R3: Index 0x50 is read-only. Writes to it are ignored. It reads as bits[1:0] = REVISION (nonzero, default 2), bit2 = `irq_ch0`, bit5 = `alt_sel`, and all other bits 0.
- R4: At index 0x57, bit4 always reads the live `irq_ch1` and ignores writes. The other seven bits are read/write, and the stored byte resets to 0x0C.
- R5: `prefetch_off` is built from four bits: [0] = index 0x51 bit6, [1] = 0x51 bit7, [2] = 0x57 bit2, [3] = 0x57 bit3. After reset all four are 1.
- R6: Index 0x51 is fully read/write and resets to 0xC0. `chan2_en` is its bit3.
- R7: Index 0x59 holds the burst setting. It is read/write, resets to 0x40 (the 512-byte default) and appears on `burst_cfg`.
- R8: Index 0x5B is a scratch byte. It returns the last value written to it and resets to 0x00.
- R9: Indices 0x52 to 0x56 and 0x58 are read/write timing bytes that reset to 0x00. `timing_bytes` packs them as follows: 0x52 in [7:0], 0x53 in [15:8], 0x54 in [23:16], 0x55 in [31:24], 0x56 in [39:32] and 0x58 in [47:40].
- R10: A data-port read of any other index returns 0xFF, and a data-port write to one has no effect.
- R11: An access with `io_wide`=1 (wider than a byte) is not claimed at either port. It gives no `rd_ack` and changes no state.
- R12: A claimed read raises `rd_ack` with `rdata` in the cycle after the strobe. A write takes effect at the clock edge that samples it, so its outputs show in the next cycle and a read issued one cycle later returns the new value.
- R13: After reset, `rd_ack`=0 and `rdata`=0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 10 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wide | input | 1 | High when the access is wider than a byte |
| io_wdata | input | 8 | Write data |
| alt_sel | input | 1 | Base strap: 0 selects 0x178, 1 selects 0x078 |
| irq_ch0 | input | 1 | Channel 0 interrupt status, synchronous |
| irq_ch1 | input | 1 | Channel 1 interrupt status, synchronous |
| rdata | output | 8 | Read data, registered |
| rd_ack | output | 1 | High in the cycle after a claimed read |
| prefetch_off | output | 4 | Per-drive prefetch disable |
| chan2_en | output | 1 | Secondary channel enable |
| burst_cfg | output | 8 | Burst register contents |
| timing_bytes | output | 48 | Packed timing bytes |

## Verification
Read results arrive one cycle after the strobe. The bench therefore drives each access at a falling edge and samples `rdata` and `rd_ack` at the next falling edge, which falls just after the registering rising edge.

Writes become visible at that same rising edge. Decoded outputs are checked at the falling edge that ends the write, and register contents through a data-port read issued in the following cycle.

Every one of the 256 indices is swept under both base straps and all four interrupt patterns. Each read is compared with a byte-level model built from the field rules, and that model is also used after full write sweeps and after ignored accesses.

// File: rtl/cfgwin_pkg.sv
// Package: shared constants and helpers for the indexed configuration window.
// Assumes 8-bit indices and byte-wide configuration storage.
package cfgwin_pkg;

    localparam int unsigned IDX_W      = 8;
    localparam int unsigned NUM_TIMING = 6;

    localparam logic [IDX_W-1:0] IX_STATUS  = 8'h50;
    localparam logic [IDX_W-1:0] IX_CTRL    = 8'h51;
    localparam logic [IDX_W-1:0] IX_CH1     = 8'h57;
    localparam logic [IDX_W-1:0] IX_BURST   = 8'h59;
    localparam logic [IDX_W-1:0] IX_SCRATCH = 8'h5B;

    // Bit positions inside the configuration bytes
    localparam int unsigned B_ST_IRQ0  = 2;
    localparam int unsigned B_ST_ALT   = 5;
    localparam int unsigned B_CT_CH2EN = 3;
    localparam int unsigned B_CT_PF0   = 6;
    localparam int unsigned B_CT_PF1   = 7;
    localparam int unsigned B_C1_PF2   = 2;
    localparam int unsigned B_C1_PF3   = 3;
    localparam int unsigned B_C1_IRQ1  = 4;

    localparam logic [7:0] RST_CTRL  = 8'hC0;
    localparam logic [7:0] RST_CH1   = 8'h0C;
    localparam logic [7:0] RST_BURST = 8'h40;

    // Index of timing byte k: five consecutive bytes, then one past the channel-1 byte
    function automatic logic [IDX_W-1:0] timing_index(input int unsigned k);
        logic [IDX_W-1:0] r;
        if (k < 5) r = 8'h52 + IDX_W'(k);
        else       r = 8'h58;
        return r;
    endfunction

endpackage

// File: rtl/cfgwin_decode.sv
// Module: cfgwin_decode
// Decodes host I/O strobes into index-port and data-port accesses.
// Assumes single-cycle strobes; wide accesses are never claimed.
module cfgwin_decode #(
    parameter int unsigned     ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_MAIN = 10'h178,
    parameter logic [ADDR_W-1:0] BASE_ALT  = 10'h078,
    parameter int unsigned     DATA_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_wide,
    input  logic              alt_sel,
    output logic              idx_wr,
    output logic              idx_rd,
    output logic              dat_wr,
    output logic              dat_rd
);

    localparam logic [ADDR_W-1:0] DATA_MAIN = BASE_MAIN + ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DATA_ALT  = BASE_ALT  + ADDR_W'(DATA_OFS);

    logic [ADDR_W-1:0] base_now;
    logic [ADDR_W-1:0] data_now;
    logic              at_index;
    logic              at_data;

    // Pick the active base pair from the strap
    always_comb begin
        base_now = alt_sel ? BASE_ALT : BASE_MAIN;
        data_now = alt_sel ? DATA_ALT : DATA_MAIN;
    end

    // Match the address against both ports, refusing wide accesses
    always_comb begin
        at_index = (io_addr == base_now) && !io_wide;
        at_data  = (io_addr == data_now) && !io_wide;
        idx_wr   = at_index && io_wr;
        idx_rd   = at_index && io_rd;
        dat_wr   = at_data  && io_wr;
        dat_rd   = at_data  && io_rd;
    end

    // R1: one address can never select both ports
    a_r1_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((idx_wr || idx_rd) && (dat_wr || dat_rd)));

    // R11: wide accesses claim nothing
    a_r11_wide_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        io_wide |-> !(idx_wr || idx_rd || dat_wr || dat_rd));

endmodule

// File: rtl/cfgwin_index.sv
// Module: cfgwin_index
// Holds the register index written through the index port.
// Assumes the index persists across any number of data accesses.
module cfgwin_index
    import cfgwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx_q
);

    // Load the index on an index-port write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata[IDX_W-1:0];
    end

    // R2: the index changes only through an index-port write
    a_r2_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(idx_q));

endmodule

// File: rtl/cfgwin_regfile.sv
// Module: cfgwin_regfile
// Stores the configuration bytes, merges read-only status, and decodes fields.
// Assumes status inputs are synchronous to clk; read mux is combinational.
module cfgwin_regfile
    import cfgwin_pkg::*;
#(
    parameter logic [1:0] REVISION = 2'd2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  wr_en,
    input  logic [7:0]            wdata,
    input  logic                  alt_sel,
    input  logic                  irq_ch0,
    input  logic                  irq_ch1,
    output logic [7:0]            rd_byte,
    output logic                  idx_mapped,
    output logic [3:0]            prefetch_off,
    output logic                  chan2_en,
    output logic [7:0]            burst_cfg,
    output logic [NUM_TIMING*8-1:0] timing_bytes
);

    localparam logic [7:0] CH1_RW_MASK = ~(8'h01 << B_C1_IRQ1);

    logic [7:0] ctrl_q;
    logic [7:0] ch1_q;
    logic [7:0] burst_q;
    logic [7:0] scratch_q;
    logic [7:0] tim_q [NUM_TIMING];
    logic [7:0] status_byte;

    // Control byte: prefetch bits for drives 0/1 and secondary enable
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= RST_CTRL;
        else if (wr_en && idx == IX_CTRL)    ctrl_q <= wdata;
    end

    // Channel-1 byte: writable bits only, interrupt bit never stored
    always_ff @(posedge clk) begin
        if (!rst_n)                          ch1_q <= RST_CH1;
        else if (wr_en && idx == IX_CH1)     ch1_q <= wdata & CH1_RW_MASK;
    end

    // Burst byte
    always_ff @(posedge clk) begin
        if (!rst_n)                          burst_q <= RST_BURST;
        else if (wr_en && idx == IX_BURST)   burst_q <= wdata;
    end

    // Scratch byte
    always_ff @(posedge clk) begin
        if (!rst_n)                          scratch_q <= '0;
        else if (wr_en && idx == IX_SCRATCH) scratch_q <= wdata;
    end

    // Timing bytes, one register per index
    for (genvar k = 0; k < NUM_TIMING; k++) begin : g_tim
        localparam logic [IDX_W-1:0] MY_IX = timing_index(k);
        // Store timing byte k
        always_ff @(posedge clk) begin
            if (!rst_n)                      tim_q[k] <= '0;
            else if (wr_en && idx == MY_IX)  tim_q[k] <= wdata;
        end
        assign timing_bytes[k*8 +: 8] = tim_q[k];
    end

    // Assemble the read-only status byte
    always_comb begin
        status_byte            = '0;
        status_byte[1:0]       = REVISION;
        status_byte[B_ST_IRQ0] = irq_ch0;
        status_byte[B_ST_ALT]  = alt_sel;
    end

    // Read mux over all mapped indices, 0xFF elsewhere
    always_comb begin
        rd_byte    = 8'hFF;
        idx_mapped = 1'b1;
        case (idx)
            IX_STATUS:  rd_byte = status_byte;
            IX_CTRL:    rd_byte = ctrl_q;
            IX_CH1:     rd_byte = ch1_q | ({7'd0, irq_ch1} << B_C1_IRQ1);
            IX_BURST:   rd_byte = burst_q;
            IX_SCRATCH: rd_byte = scratch_q;
            default:    idx_mapped = 1'b0;
        endcase
        for (int k = 0; k < NUM_TIMING; k++) begin
            if (idx == timing_index(k)) begin
                rd_byte    = tim_q[k];
                idx_mapped = 1'b1;
            end
        end
    end

    // Decode the scattered fields
    always_comb begin
        prefetch_off = {ch1_q[B_C1_PF3], ch1_q[B_C1_PF2], ctrl_q[B_CT_PF1], ctrl_q[B_CT_PF0]};
        chan2_en     = ctrl_q[B_CT_CH2EN];
        burst_cfg    = burst_q;
    end

    // R5: prefetch bits move only on a data write
    a_r5_prefetch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prefetch_off));

    // R8: scratch changes only when written at its own index
    a_r8_scratch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == IX_SCRATCH) |=> $stable(scratch_q));

    // R4: the stored channel-1 byte never keeps the status bit
    a_r4_irq_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ch1_q[B_C1_IRQ1]);

endmodule

// File: rtl/cfgwin_port.sv
// Module: cfgwin_port (top)
// Byte-wide indexed window onto the controller configuration bytes.
// Assumes one strobe per cycle; read data is registered one cycle after the strobe.
module cfgwin_port
    import cfgwin_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter logic [1:0]  REVISION = 2'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_wide,
    input  logic [7:0]        io_wdata,
    input  logic              alt_sel,
    input  logic              irq_ch0,
    input  logic              irq_ch1,
    output logic [7:0]        rdata,
    output logic              rd_ack,
    output logic [3:0]        prefetch_off,
    output logic              chan2_en,
    output logic [7:0]        burst_cfg,
    output logic [47:0]       timing_bytes
);

    logic             idx_wr, idx_rd, dat_wr, dat_rd;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       rd_byte;
    logic             idx_mapped;

    cfgwin_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_MAIN (ADDR_W'(10'h178)),
        .BASE_ALT  (ADDR_W'(10'h078)),
        .DATA_OFS  (4)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_wide (io_wide),
        .alt_sel (alt_sel),
        .idx_wr  (idx_wr),
        .idx_rd  (idx_rd),
        .dat_wr  (dat_wr),
        .dat_rd  (dat_rd)
    );

    cfgwin_index u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (io_wdata),
        .idx_q  (idx_q)
    );

    cfgwin_regfile #(
        .REVISION (REVISION)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx          (idx_q),
        .wr_en        (dat_wr),
        .wdata        (io_wdata),
        .alt_sel      (alt_sel),
        .irq_ch0      (irq_ch0),
        .irq_ch1      (irq_ch1),
        .rd_byte      (rd_byte),
        .idx_mapped   (idx_mapped),
        .prefetch_off (prefetch_off),
        .chan2_en     (chan2_en),
        .burst_cfg    (burst_cfg),
        .timing_bytes (timing_bytes)
    );

    // Register the read result and its acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_ack <= 1'b0;
        end else begin
            rd_ack <= idx_rd || dat_rd;
            if (idx_rd)      rdata <= idx_q;
            else if (dat_rd) rdata <= rd_byte;
        end
    end

    // R12: every claimed read is acknowledged next cycle
    a_r12_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_rd || dat_rd) |=> rd_ack);

    // R1: unclaimed reads are never acknowledged
    a_r1_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_rd || dat_rd) |=> !rd_ack);

    // R10: unmapped indices read as all ones
    a_r10_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !idx_mapped) |=> (rdata == 8'hFF));

    // R3: the revision field seen by the host is never zero
    a_r3_rev_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && idx_q == IX_STATUS) |=> (rdata[1:0] != 2'b00));

endmodule

// File: tb/tb_cfgwin_port.sv
// Bench: sweeps every index under both straps with a byte-level field model.
module tb_cfgwin_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] io_addr;
    logic       io_wr, io_rd, io_wide;
    logic [7:0] io_wdata;
    logic       alt_sel, irq_ch0, irq_ch1;
    logic [7:0] rdata;
    logic       rd_ack;
    logic [3:0] prefetch_off;
    logic       chan2_en;
    logic [7:0] burst_cfg;
    logic [47:0] timing_bytes;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;

    // Model state
    logic [7:0] m51, m57, m59, m5b, midx;
    logic [7:0] mt [6];

    cfgwin_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wide(io_wide), .io_wdata(io_wdata), .alt_sel(alt_sel), .irq_ch0(irq_ch0),
        .irq_ch1(irq_ch1), .rdata(rdata), .rd_ack(rd_ack), .prefetch_off(prefetch_off),
        .chan2_en(chan2_en), .burst_cfg(burst_cfg), .timing_bytes(timing_bytes)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [9:0] base_of(input logic a);
        return a ? 10'h078 : 10'h178;
    endfunction

    function automatic int tix(input logic [7:0] i);
        int r = -1;
        if (i >= 8'h52 && i <= 8'h56) r = int'(i - 8'h52);
        else if (i == 8'h58) r = 5;
        return r;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] i);
        logic [7:0] r = 8'hFF;
        if (i == 8'h50) r = {2'b00, alt_sel, 2'b00, irq_ch0, 2'd2};
        else if (i == 8'h51) r = m51;
        else if (i == 8'h57) r = m57 | {3'b000, irq_ch1, 4'b0000};
        else if (i == 8'h59) r = m59;
        else if (i == 8'h5B) r = m5b;
        else if (tix(i) >= 0) r = mt[tix(i)];
        return r;
    endfunction

    task automatic model_write(input logic [7:0] i, input logic [7:0] d);
        if (i == 8'h51) m51 = d;
        else if (i == 8'h57) m57 = d & 8'hEF;
        else if (i == 8'h59) m59 = d;
        else if (i == 8'h5B) m5b = d;
        else if (tix(i) >= 0) mt[tix(i)] = d;
    endtask

    // One bus cycle driven at a falling edge; outputs sampled at the next falling edge
    task automatic bus(input logic [9:0] a, input logic w, input logic r,
                       input logic wide, input logic [7:0] d);
        io_addr = a; io_wr = w; io_rd = r; io_wide = wide; io_wdata = d;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; io_wide = 1'b0;
    endtask

    task automatic chk_fields(input string tag);
        chk({tag, " R5 prefetch_off"}, 64'(prefetch_off), 64'({m57[3], m57[2], m51[7], m51[6]}));
        chk({tag, " R6 chan2_en"}, 64'(chan2_en), 64'(m51[3]));
        chk({tag, " R7 burst_cfg"}, 64'(burst_cfg), 64'(m59));
        chk({tag, " R9 timing_bytes"}, 64'(timing_bytes),
            64'({mt[5], mt[4], mt[3], mt[2], mt[1], mt[0]}));
    endtask

    // Select index i, read it back at the index port, then read the data port
    task automatic read_index(input logic [7:0] i, input string tag);
        bus(base_of(alt_sel), 1'b1, 1'b0, 1'b0, i);
        midx = i;
        bus(base_of(alt_sel), 1'b0, 1'b1, 1'b0, 8'h00);
        chk({tag, " R2 index readback"}, 64'(rdata), 64'(i));
        bus(base_of(alt_sel) + 10'd4, 1'b0, 1'b1, 1'b0, 8'h00);
        chk({tag, " R12 rd_ack"}, 64'(rd_ack), 64'(1));
        chk({tag, " R3/R4/R10 data read"}, 64'(rdata), 64'(exp_read(i)));
    endtask

    task automatic write_index(input logic [7:0] i, input logic [7:0] d);
        bus(base_of(alt_sel), 1'b1, 1'b0, 1'b0, i);
        midx = i;
        bus(base_of(alt_sel) + 10'd4, 1'b1, 1'b0, 1'b0, d);
        model_write(i, d);
    endtask

    initial begin
        #1_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; io_addr = '0; io_wr = 0; io_rd = 0; io_wide = 0; io_wdata = 0;
        alt_sel = 0; irq_ch0 = 0; irq_ch1 = 0;
        m51 = 8'hC0; m57 = 8'h0C; m59 = 8'h40; m5b = 8'h00; midx = 8'h00;
        for (int k = 0; k < 6; k++) mt[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state and R5-R9 reset fields
        chk("R13 rd_ack reset", 64'(rd_ack), 64'(0));
        chk("R13 rdata reset", 64'(rdata), 64'(0));
        chk_fields("R13 reset");
        bus(10'h178, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R2 index reset value", 64'(rdata), 64'(0));

        // Full read sweep under both straps and all interrupt patterns (R1 R3 R4 R10)
        for (int a = 0; a < 2; a++) begin
            for (int q = 0; q < 4; q++) begin
                alt_sel = a[0]; irq_ch0 = q[0]; irq_ch1 = q[1];
                for (int i = 0; i < 256; i++) read_index(8'(i), "sweep");
            end
        end

        // Write sweeps with two patterns, then read everything back (R3 R4 R6-R10)
        irq_ch0 = 1; irq_ch1 = 1;
        for (int p = 0; p < 2; p++) begin
            alt_sel = p[0];
            for (int i = 0; i < 256; i++) write_index(8'(i), (p == 0) ? (8'(i) ^ 8'hA5) : ~(8'(i) ^ 8'hA5));
            chk_fields("R9 after write sweep");
            for (int i = 0; i < 256; i++) read_index(8'(i), "R8 readback");
        end

        // R12: a write's field update shows one cycle later, readable the next
        write_index(8'h51, 8'h08);
        chk("R12 chan2_en after write", 64'(chan2_en), 64'(1));
        chk("R5 prefetch drives 0/1 on", 64'(prefetch_off[1:0]), 64'(0));
        write_index(8'h57, 8'hFF);
        chk("R4 stored byte fields", 64'(prefetch_off[3:2]), 64'(3));
        irq_ch1 = 0;
        read_index(8'h57, "R4 irq1 low");

        // R2: several data accesses after one index write
        bus(10'h078, 1'b1, 1'b0, 1'b0, 8'h5B);
        bus(10'h07C, 1'b1, 1'b0, 1'b0, 8'h3C); m5b = 8'h3C;
        bus(10'h07C, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R2 data read 1 after one index write", 64'(rdata), 64'(8'h3C));
        bus(10'h07C, 1'b1, 1'b0, 1'b0, 8'hC3); m5b = 8'hC3;
        bus(10'h07C, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R8 scratch last written", 64'(rdata), 64'(8'hC3));

        // R11: wide accesses ignored at both ports
        bus(10'h07C, 1'b1, 1'b0, 1'b1, 8'h11);
        bus(10'h078, 1'b1, 1'b0, 1'b1, 8'h51);
        bus(10'h07C, 1'b0, 1'b1, 1'b1, 8'h00);
        chk("R11 wide read no ack", 64'(rd_ack), 64'(0));
        bus(10'h078, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R11 index untouched by wide write", 64'(rdata), 64'(8'h5B));
        bus(10'h07C, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R11 scratch untouched by wide write", 64'(rdata), 64'(8'hC3));

        // R1: other addresses, including the unselected base pair, claim nothing
        bus(10'h17C, 1'b1, 1'b0, 1'b0, 8'h77);
        bus(10'h178, 1'b1, 1'b0, 1'b0, 8'h59);
        bus(10'h079, 1'b1, 1'b0, 1'b0, 8'h59);
        bus(10'h17C, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R1 unselected base no ack", 64'(rd_ack), 64'(0));
        bus(10'h07C, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R1 scratch untouched by foreign writes", 64'(rdata), 64'(8'hC3));

        // R3 / R10: writes to read-only and unmapped indices have no effect
        write_index(8'h50, 8'hFF);
        read_index(8'h50, "R3 after write");
        write_index(8'h5A, 8'h00);
        read_index(8'h5A, "R10 after write");
        chk_fields("R10 fields unchanged");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule